// File: doc/BRIEF.md
# Packed Calendar Clockwatch Counter

This block keeps wall-clock time and date in hardware. Seconds, minutes, hours, weekday, day of month and month share one packed 32-bit word. The year is a separate 32-bit word that holds four BCD digits: a two-digit year and a two-digit century. The counter moves forward by one second on each cycle in which the one-second strobe `tick` and the enable `run_en` are both high. It handles month lengths, the leap-year rule for February and decimal carry in the year.

Software sets the calendar by loading the year word and the packed time word through the load strobes. An alarm compares the calendar against a packed match word and a year-match word. The alarm flag latches on the second in which counting brings both words to equality. It stays set until it is cleared. All pins are plain control and status pins: no data stream enters or leaves the block, so there is no valid/ready handshake.

Top module: `cal_clockwatch`

## Requirements
- R1: After reset, `time_q` reads 0x0212_0000 (January 1st, weekday 1, 00:00:00), `year_q` reads 0x0000_2000 and `alarm_flag` is low.
- R2: The packed time word has seconds in [5:0], minutes in [11:6], hours in [16:12], weekday in [19:17], day of month in [24:20] and month in [28:25]. A `time_load` pulse writes bits [28:0] of `time_load_val` at the next edge and wins over an advance in the same cycle. Bits [31:29] of `time_q` always read zero.
- R3: A `year_load` pulse writes bits [15:0] of `year_load_val` at the next edge. Bits [7:0] are the BCD year within the century and bits [15:8] are the BCD century. The load wins over any year carry in the same cycle, and bits [31:16] of `year_q` always read zero.
- R4: Both words hold their value in any cycle without a load in which `run_en` or `tick` is low.
- R5: Each advance steps seconds 0..59. At 59 the seconds wrap to 0 and minutes step. Minutes wrap from 59 to 0 and step the hours, and hours wrap from 23 to 0 at the end of the day.
- R6: Weekday runs 1..7 (1 = Sunday), steps once at each end of day and wraps from 7 to 1.
- R7: Day of month starts at 1 and rolls to 1 after the last day of the month: 31 days for months 1, 3, 5, 7, 8, 10 and 12, and 30 days for months 4, 6, 9 and 11. Month runs 1..12 (1 = January) and wraps from 12 to 1 with a carry into the year.
- R8: February has 29 days when the four-digit year is divisible by 4 and is not a century year, or is divisible by 400. Otherwise it has 28 days.
- R9: A year carry increments the BCD year with decimal carry between digits. Year 99 rolls into the century byte, and 9999 wraps to 0000.
- R10: `alarm_flag` sets at the edge at which an advance (without a time load) makes bits [28:0] of the time equal to those of `match_time` and bits [15:0] of the year equal to those of `match_year`. The other bits of the match words are ignored. A load to a matching value does not set the flag.
- R11: `alarm_flag` stays set until a cycle with `alarm_clr` high clears it. When a setting advance and `alarm_clr` fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Counting enable |
| tick | input | 1 | One-second strobe, one cycle wide |
| time_load | input | 1 | Load strobe for the packed time word |
| time_load_val | input | 32 | Value for the packed time word |
| year_load | input | 1 | Load strobe for the year word |
| year_load_val | input | 32 | Value for the BCD year word |
| match_time | input | 32 | Alarm compare value for the packed time word |
| match_year | input | 32 | Alarm compare value for the year word |
| alarm_clr | input | 1 | Clears the alarm flag |
| time_q | output | 32 | Current packed time word |
| year_q | output | 32 | Current BCD year word |
| alarm_flag | output | 1 | Latched alarm flag |

## Verification
The alarm set and the alarm clear can fall in the same cycle. The bench provokes this by loading the calendar to one second before the match value, then raising `tick` and `alarm_clr` together in a single cycle. It judges the result right after that edge, where the flag must be high, and again after a later clear-only cycle, where it must be low. A load that coincides with a strobe is also provoked, and the loaded value must appear unchanged.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int WDAY_W = 3;
  localparam int MDAY_W = 5;
  localparam int MON_W  = 4;
  localparam int WORD_W = 32;
  localparam int USED_W = SEC_W + MIN_W + HOUR_W + WDAY_W + MDAY_W + MON_W;
  localparam int RSVD_W = WORD_W - USED_W;
  localparam int BCD_DIGITS = 4;
  localparam int YEAR_W = 4 * BCD_DIGITS;

  localparam logic [SEC_W-1:0]  SEC_LAST  = SEC_W'(59);
  localparam logic [MIN_W-1:0]  MIN_LAST  = MIN_W'(59);
  localparam logic [HOUR_W-1:0] HOUR_LAST = HOUR_W'(23);
  localparam logic [WDAY_W-1:0] WDAY_LAST = WDAY_W'(7);
  localparam logic [MON_W-1:0]  MON_LAST  = MON_W'(12);

  localparam logic [WORD_W-1:0] TIME_MASK = {{RSVD_W{1'b0}}, {USED_W{1'b1}}};
  localparam logic [WORD_W-1:0] YEAR_MASK = {{(WORD_W-YEAR_W){1'b0}}, {YEAR_W{1'b1}}};

  typedef struct packed {
    logic [RSVD_W-1:0] rsvd;
    logic [MON_W-1:0]  mon;
    logic [MDAY_W-1:0] mday;
    logic [WDAY_W-1:0] wday;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } cal_time_t;

  localparam cal_time_t TIME_AT_RESET = '{rsvd: '0, mon: MON_W'(1), mday: MDAY_W'(1),
                                          wday: WDAY_W'(1), hour: '0, min: '0, sec: '0};

  function automatic logic [MDAY_W-1:0] month_days(input logic [MON_W-1:0] mon, input logic leap);
    case (mon)
      MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): month_days = MDAY_W'(30);
      MON_W'(2): month_days = leap ? MDAY_W'(29) : MDAY_W'(28);
      default:   month_days = MDAY_W'(31);
    endcase
  endfunction
endpackage

// File: rtl/cal_year_step.sv
module cal_year_step #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] year_i,
  output logic [4*DIGITS-1:0] year_o,
  output logic                leap_o
);
  logic [DIGITS-1:0] carry;
  assign carry[0] = 1'b1;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [3:0] dig;
    logic       top;
    assign dig = year_i[4*d +: 4];
    assign top = dig >= 4'd9;
    assign year_o[4*d +: 4] = !carry[d] ? dig : (top ? 4'd0 : dig + 4'd1);
    if (d < DIGITS - 1) begin : g_chain
      assign carry[d+1] = carry[d] && top;
    end
  end

  logic [6:0] yy_bin;
  logic [6:0] cc_bin;
  assign yy_bin = 7'(year_i[7:4]) * 7'd10 + 7'(year_i[3:0]);
  assign cc_bin = 7'(year_i[15:12]) * 7'd10 + 7'(year_i[11:8]);
  assign leap_o = (yy_bin[1:0] == 2'd0) && ((yy_bin != 7'd0) || (cc_bin[1:0] == 2'd0));
endmodule

// File: rtl/cal_time_step.sv
module cal_time_step
  import cal_pkg::*;
(
  input  cal_time_t cur_i,
  input  logic      leap_i,
  output cal_time_t nxt_o,
  output logic      year_carry_o
);
  logic [MDAY_W-1:0] last_day;
  logic sec_wrap, min_wrap, hour_wrap, mday_wrap, mon_wrap;

  always_comb begin
    last_day  = month_days(cur_i.mon, leap_i);
    sec_wrap  = cur_i.sec >= SEC_LAST;
    min_wrap  = sec_wrap && (cur_i.min >= MIN_LAST);
    hour_wrap = min_wrap && (cur_i.hour >= HOUR_LAST);
    mday_wrap = hour_wrap && (cur_i.mday >= last_day);
    mon_wrap  = mday_wrap && (cur_i.mon >= MON_LAST);

    nxt_o      = cur_i;
    nxt_o.rsvd = '0;
    nxt_o.sec  = sec_wrap ? '0 : cur_i.sec + SEC_W'(1);
    if (sec_wrap) nxt_o.min  = min_wrap ? '0 : cur_i.min + MIN_W'(1);
    if (min_wrap) nxt_o.hour = hour_wrap ? '0 : cur_i.hour + HOUR_W'(1);
    if (hour_wrap) begin
      nxt_o.wday = (cur_i.wday >= WDAY_LAST) ? WDAY_W'(1) : cur_i.wday + WDAY_W'(1);
      nxt_o.mday = mday_wrap ? MDAY_W'(1) : cur_i.mday + MDAY_W'(1);
    end
    if (mday_wrap) nxt_o.mon = mon_wrap ? MON_W'(1) : cur_i.mon + MON_W'(1);
    year_carry_o = mon_wrap;
  end
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic [WORD_W-1:0] time_i,
  input  logic [WORD_W-1:0] year_i,
  input  logic [WORD_W-1:0] match_time_i,
  input  logic [WORD_W-1:0] match_year_i,
  input  logic              clr_i,
  output logic              flag_o
);
  logic hit;
  assign hit = adv_i
            && (((time_i ^ match_time_i) & TIME_MASK) == '0)
            && (((year_i ^ match_year_i) & YEAR_MASK) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (hit)   flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/cal_clockwatch.sv
module cal_clockwatch
  import cal_pkg::*;
#(
  parameter logic [YEAR_W-1:0] RESET_YEAR = 16'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              tick,
  input  logic              time_load,
  input  logic [WORD_W-1:0] time_load_val,
  input  logic              year_load,
  input  logic [WORD_W-1:0] year_load_val,
  input  logic [WORD_W-1:0] match_time,
  input  logic [WORD_W-1:0] match_year,
  input  logic              alarm_clr,
  output logic [WORD_W-1:0] time_q,
  output logic [WORD_W-1:0] year_q,
  output logic              alarm_flag
);
  cal_time_t         time_r, time_d, time_nxt;
  logic [YEAR_W-1:0] year_r, year_d, year_nxt;
  logic              leap, year_carry, adv;

  assign adv = run_en && tick;

  cal_year_step #(.DIGITS(BCD_DIGITS)) u_year (
    .year_i (year_r),
    .year_o (year_nxt),
    .leap_o (leap)
  );

  cal_time_step u_time (
    .cur_i        (time_r),
    .leap_i       (leap),
    .nxt_o        (time_nxt),
    .year_carry_o (year_carry)
  );

  always_comb begin
    time_d = time_r;
    year_d = year_r;
    if (adv) begin
      time_d = time_nxt;
      if (year_carry) year_d = year_nxt;
    end
    if (time_load) time_d = cal_time_t'(time_load_val & TIME_MASK);
    if (year_load) year_d = YEAR_W'(year_load_val & YEAR_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_r <= TIME_AT_RESET;
      year_r <= RESET_YEAR;
    end else begin
      time_r <= time_d;
      year_r <= year_d;
    end
  end

  cal_alarm u_alarm (
    .clk          (clk),
    .rst_n        (rst_n),
    .adv_i        (adv && !time_load),
    .time_i       (time_d),
    .year_i       ({{(WORD_W-YEAR_W){1'b0}}, year_d}),
    .match_time_i (match_time),
    .match_year_i (match_year),
    .clr_i        (alarm_clr),
    .flag_o       (alarm_flag)
  );

  assign time_q = time_r;
  assign year_q = {{(WORD_W-YEAR_W){1'b0}}, year_r};
endmodule

// File: rtl/cal_clockwatch_chk.sv
module cal_clockwatch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run_en,
  input logic        tick,
  input logic        time_load,
  input logic [31:0] time_load_val,
  input logic        year_load,
  input logic        alarm_clr,
  input logic [31:0] time_q,
  input logic [31:0] year_q,
  input logic        alarm_flag
);
  // R2
  time_load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    time_load |=> time_q[28:0] == $past(time_load_val[28:0]));

  // R2 R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    time_q[31:29] == 3'd0 && year_q[31:16] == 16'd0);

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(run_en && tick) && !time_load && !year_load) |=> $stable(time_q) && $stable(year_q));

  // R5
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && tick && !time_load && time_q[5:0] < 6'd59) |=> time_q[5:0] == $past(time_q[5:0]) + 6'd1);

  // R10
  alarm_needs_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(run_en && tick && !time_load));

  // R11
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !alarm_clr) |=> alarm_flag);

  // R11
  alarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_clr && !(run_en && tick)) |=> !alarm_flag);
endmodule

bind cal_clockwatch cal_clockwatch_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .run_en        (run_en),
  .tick          (tick),
  .time_load     (time_load),
  .time_load_val (time_load_val),
  .year_load     (year_load),
  .alarm_clr     (alarm_clr),
  .time_q        (time_q),
  .year_q        (year_q),
  .alarm_flag    (alarm_flag)
);

// File: tb/cal_clockwatch_test.sv
module cal_clockwatch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0, tick = 1'b0, time_load = 1'b0, year_load = 1'b0, alarm_clr = 1'b0;
  logic [31:0] time_load_val = '0, year_load_val = '0, match_time = '1, match_year = '1;
  logic [31:0] time_q, year_q;
  logic        alarm_flag;

  int n_cmp = 0, n_bad = 0;
  int m_s, m_mi, m_h, m_wd, m_md, m_mo, m_y;

  always #10 clk = ~clk;

  cal_clockwatch uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick),
    .time_load(time_load), .time_load_val(time_load_val),
    .year_load(year_load), .year_load_val(year_load_val),
    .match_time(match_time), .match_year(match_year), .alarm_clr(alarm_clr),
    .time_q(time_q), .year_q(year_q), .alarm_flag(alarm_flag)
  );

  function automatic logic [31:0] pk(int mo, int md, int wd, int h, int mi, int s);
    return 32'((mo << 25) | (md << 20) | (wd << 17) | (h << 12) | (mi << 6) | s);
  endfunction

  function automatic logic [31:0] by(int y);
    int lo = y % 100;
    int c  = y / 100;
    return 32'(((c / 10) << 12) | ((c % 10) << 8) | ((lo / 10) << 4) | (lo % 10));
  endfunction

  function automatic bit is_leap(int y);
    return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
  endfunction

  function automatic int mdays(int mo, int y);
    if (mo == 2) return is_leap(y) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_cal(string tag);
    cmp(tag, time_q, pk(m_mo, m_md, m_wd, m_h, m_mi, m_s));
    cmp(tag, year_q, by(m_y));
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic m_adv();
    m_s++;
    if (m_s == 60) begin
      m_s = 0; m_mi++;
      if (m_mi == 60) begin
        m_mi = 0; m_h++;
        if (m_h == 24) begin
          m_h = 0;
          m_wd = (m_wd == 7) ? 1 : m_wd + 1;
          m_md++;
          if (m_md > mdays(m_mo, m_y)) begin
            m_md = 1; m_mo++;
            if (m_mo == 13) begin
              m_mo = 1;
              m_y = (m_y + 1) % 10000;
            end
          end
        end
      end
    end
  endtask

  task automatic load_cal(int y, int mo, int md, int wd, int h, int mi, int s);
    m_y = y; m_mo = mo; m_md = md; m_wd = wd; m_h = h; m_mi = mi; m_s = s;
    time_load_val = pk(mo, md, wd, h, mi, s);
    year_load_val = by(y);
    time_load = 1'b1; year_load = 1'b1;
    step();
    time_load = 1'b0; year_load = 1'b0;
  endtask

  task automatic advance(string tag);
    run_en = 1'b1; tick = 1'b1;
    step();
    tick = 1'b0;
    m_adv();
    check_cal(tag);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int years[7] = '{1999, 2000, 2023, 2024, 2100, 2399, 9999};
    logic [31:0] mt;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    cmp("R1 time", time_q, 32'h0212_0000);
    cmp("R1 year", year_q, 32'h0000_2000);
    cmp("R1 alarm", {31'd0, alarm_flag}, 32'd0);

    // R4 strobe without enable, enable without strobe
    m_y = 2000; m_mo = 1; m_md = 1; m_wd = 1; m_h = 0; m_mi = 0; m_s = 0;
    run_en = 1'b0; tick = 1'b1;
    repeat (4) step();
    check_cal("R4 run_en low");
    run_en = 1'b1; tick = 1'b0;
    repeat (4) step();
    check_cal("R4 tick low");

    // R7 R8 R9 month ends across many years
    foreach (years[i]) begin
      for (int mo = 1; mo <= 12; mo++) begin
        string tg;
        tg = (mo == 2) ? "R8 february" : (mo == 12) ? "R9 year end" : "R7 month end";
        load_cal(years[i], mo, mdays(mo, years[i]), ((mo + i) % 7) + 1, 23, 59, 58);
        check_cal("R2 load");
        for (int k = 0; k < 3; k++) advance(tg);
      end
    end

    // R5 R6 continuous run across a day boundary with weekday 7
    load_cal(2024, 2, 28, 7, 23, 0, 0);
    for (int k = 0; k < 3700; k++) advance((k % 2 == 0) ? "R5 run" : "R6 run");
    cmp("R6 weekday wrapped", 32'(time_q[19:17]), 32'd1);

    // R2 load wins over advance, reserved bits read zero
    time_load_val = 32'hFFFF_FFFF; time_load = 1'b1; tick = 1'b1; run_en = 1'b1;
    step();
    time_load = 1'b0; tick = 1'b0;
    cmp("R2 masked load over tick", time_q, 32'h1FFF_FFFF);
    // R3 year word masking and load over year carry
    load_cal(2024, 12, 31, 3, 23, 59, 59);
    year_load_val = 32'hFFFF_1234; year_load = 1'b1; tick = 1'b1;
    step();
    year_load = 1'b0; tick = 1'b0;
    cmp("R3 year load over carry", year_q, 32'h0000_1234);
    cmp("R3 time still advanced", time_q, pk(1, 1, 4, 0, 0, 0));

    // R10 alarm on the matching second, upper match bits ignored
    load_cal(2024, 3, 10, 1, 12, 0, 0);
    mt = pk(3, 10, 1, 12, 0, 2);
    match_time = mt | 32'hE000_0000;
    match_year = by(2024) | 32'hABCD_0000;
    advance("R10 before match");
    cmp("R10 not yet", {31'd0, alarm_flag}, 32'd0);
    advance("R10 match");
    cmp("R10 set on match", {31'd0, alarm_flag}, 32'd1);
    advance("R11 hold");
    cmp("R11 sticky", {31'd0, alarm_flag}, 32'd1);
    alarm_clr = 1'b1; step(); alarm_clr = 1'b0;
    cmp("R11 cleared", {31'd0, alarm_flag}, 32'd0);

    // R10 loading a matching value does not set the flag
    load_cal(2024, 3, 10, 1, 12, 0, 2);
    step();
    cmp("R10 load no alarm", {31'd0, alarm_flag}, 32'd0);

    // R10 year mismatch blocks the alarm
    load_cal(2025, 3, 10, 1, 12, 0, 1);
    advance("R10 year differs");
    cmp("R10 year mismatch", {31'd0, alarm_flag}, 32'd0);

    // R11 set and clear in the same cycle
    load_cal(2024, 3, 10, 1, 12, 0, 1);
    alarm_clr = 1'b1;
    advance("R11 collide");
    alarm_clr = 1'b0;
    cmp("R11 set beats clear", {31'd0, alarm_flag}, 32'd1);
    alarm_clr = 1'b1; step(); alarm_clr = 1'b0;
    cmp("R11 clear after collide", {31'd0, alarm_flag}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule